// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This block holds two time-of-day alarm channels for a real-time-clock subsystem. Once per second it compares each channel's stored BCD alarm bytes with the running time. The comparison leaves out every field whose mask bit (bit 7 of that alarm byte) is set. A match sets a sticky flag. Software can clear the flag but can never set it. The second channel has no seconds byte, so it can only fire at second 00.

The block also owns the control register and the status register. The control register selects between two uses of a single active-low open-drain output:

- an interrupt line, driven by the flags and their enables;
- a square wave, picked from one of four rate taps that the clock divider supplies.

The status register also holds an oscillator-stop flag. It is set by an oscillator-stop event, or when the oscillator-off control bit goes from 0 to 1. Software clears it by writing 0. While the subsystem runs from the backup supply, the output is released unless battery operation of the output is enabled.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset the control register reads 0x18, the status register reads 0x80 (oscillator-stop flag set, both alarm flags clear) and `irq_oe` is 0.
- R2: Channel 1 uses mask bits {day[7],hour[7],min[7],sec[7]}. Pattern 1111 matches every second. 1110 compares seconds. 1100 compares minutes and seconds. 1000 also compares hours. 0000 also compares day/date. Time fields compare on bits 6:0 of the alarm byte.
- R3: In a day/date alarm byte, bit 6 = 1 compares bits 5:0 against `now_wday`, and bit 6 = 0 compares them against `now_mday`.
- R4: Channel 2 matches only when `now_sec` is 00. Its mask pattern {day[7],hour[7],min[7]} = 111 fires once per minute. 110 adds minutes, 100 adds hours, and 000 adds day/date.
- R5: Matches are evaluated only in a cycle with `tick_1hz` high. The flag (status bit 0 for channel 1, bit 1 for channel 2) reads 1 in the cycle after that tick.
- R6: A status write with bit n = 0 clears alarm flag n, and bit n = 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R7: With control bit 2 = 1, `irq_oe` goes to (flag1 AND ctrl bit 0) OR (flag2 AND ctrl bit 1).
- R8: With control bit 2 = 0, `irq_oe` is the inverse of `wave_taps[ctrl[4:3]]`. Taps 0..3 are 1 Hz, 4.096 kHz, 8.192 kHz and 32.768 kHz.
- R9: While `on_backup` = 1 and control bit 5 = 0, `irq_oe` is 0. With bit 5 = 1 the output behaves as in R7/R8.
- R10: The oscillator-stop flag (status bit 7) is set by an `osc_stop` pulse or by a control write that takes bit 7 from 0 to 1. It is cleared only by a status write with bit 7 = 0.
- R11: `irq_oe` is registered and reflects the state one clock earlier. `irq_d` is always 0.
- R12: A control write loads `wr_data` with bit 6 forced to 0. Without a write the control register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe per second; alarms are evaluated in this cycle |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours byte, bits 6:0 |
| now_wday | input | 6 | Current day of week |
| now_mday | input | 6 | Current date of month, BCD |
| al1_sec | input | 8 | Channel 1 seconds byte, bit 7 mask |
| al1_min | input | 8 | Channel 1 minutes byte, bit 7 mask |
| al1_hour | input | 8 | Channel 1 hours byte, bit 7 mask |
| al1_day | input | 8 | Channel 1 day/date byte, bit 7 mask, bit 6 select |
| al2_min | input | 8 | Channel 2 minutes byte, bit 7 mask |
| al2_hour | input | 8 | Channel 2 hours byte, bit 7 mask |
| al2_day | input | 8 | Channel 2 day/date byte, bit 7 mask, bit 6 select |
| ctrl_we | input | 1 | Control register write strobe |
| stat_we | input | 1 | Status register write-to-clear strobe |
| wr_data | input | 8 | Write data for both registers |
| osc_stop | input | 1 | Oscillator-stop event pulse |
| on_backup | input | 1 | Subsystem is powered from the backup supply |
| wave_taps | input | 4 | Square-wave rate taps from the divider |
| ctrl_q | output | 8 | Control register contents |
| stat_q | output | 8 | Status register contents |
| irq_oe | output | 1 | Open-drain pull-down enable (1 drives the pin low) |
| irq_d | output | 1 | Open-drain data value, constant 0 |

## Verification
The hardest case to reach is a clash at one clock edge: an alarm match on the second strobe in the same cycle as a status write that clears the very flag the match sets. The bench raises `tick_1hz` and `stat_we` together, with write data 0, while the time matches channel 1. A second hard case is the release of the output on backup power, because a flag and its enable must already be holding the line asserted. The stimulus first asserts the interrupt and only then raises `on_backup`, and later sets the battery-enable bit to bring the output back. A behavioural reference model compares every output on every clock while masks, select bits and rates are swept.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int BYTE_W = 8;
  localparam int FLD_W  = 7;   // compared bits of a time alarm byte
  localparam int DAY_W  = 6;   // compared bits of a day/date alarm byte
  localparam int MSK_B  = 7;   // mask bit in every alarm byte
  localparam int SEL_B  = 6;   // day/date select bit

  // control register bit positions (decoded by software)
  localparam int CB_OSC_OFF = 7;
  localparam int CB_BATT_EN = 5;
  localparam int CB_RATE_LO = 3;
  localparam int CB_INT_MOD = 2;
  localparam int CB_IE_LO   = 0;

  // status register bit positions
  localparam int SB_OSF     = 7;
  localparam int SB_FLAG_LO = 0;

  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'h18;
  localparam logic [BYTE_W-1:0] CTRL_WMASK = 8'hBF;
  localparam logic [BYTE_W-1:0] ALL_MASKED = 8'h80;
endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter bit NEED_SEC_ZERO = 1'b0
) (
  input  logic [FLD_W-1:0]  now_sec,
  input  logic [FLD_W-1:0]  now_min,
  input  logic [FLD_W-1:0]  now_hour,
  input  logic [DAY_W-1:0]  now_wday,
  input  logic [DAY_W-1:0]  now_mday,
  input  logic [BYTE_W-1:0] al_sec,
  input  logic [BYTE_W-1:0] al_min,
  input  logic [BYTE_W-1:0] al_hour,
  input  logic [BYTE_W-1:0] al_day,
  output logic              hit
);
  logic sec_ok, min_ok, hour_ok, day_ok, zero_ok;
  logic [DAY_W-1:0] day_src;

  assign sec_ok  = al_sec[MSK_B]  | (al_sec[FLD_W-1:0]  == now_sec);
  assign min_ok  = al_min[MSK_B]  | (al_min[FLD_W-1:0]  == now_min);
  assign hour_ok = al_hour[MSK_B] | (al_hour[FLD_W-1:0] == now_hour);
  assign day_src = al_day[SEL_B] ? now_wday : now_mday;
  assign day_ok  = al_day[MSK_B]  | (al_day[DAY_W-1:0]  == day_src);

  generate
    if (NEED_SEC_ZERO) begin : g_sec_zero
      assign zero_ok = (now_sec == '0);
    end else begin : g_any_sec
      assign zero_ok = 1'b1;
    end
  endgenerate

  assign hit = sec_ok & min_ok & hour_ok & day_ok & zero_ok;
endmodule

// File: rtl/tod_irq_out.sv
module tod_irq_out #(
  parameter int N_RATES = 4,
  parameter int RS_W    = $clog2(N_RATES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               int_mode,
  input  logic               batt_en,
  input  logic               on_backup,
  input  logic [RS_W-1:0]    rate_sel,
  input  logic [N_RATES-1:0] wave_taps,
  input  logic               irq_req,
  output logic               irq_oe
);
  logic wave;
  assign wave = wave_taps[rate_sel];

  always_ff @(posedge clk) begin
    if (rst)                        irq_oe <= 1'b0;
    else if (on_backup && !batt_en) irq_oe <= 1'b0;
    else if (int_mode)              irq_oe <= irq_req;
    else                            irq_oe <= ~wave;
  end
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter int N_RATES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_1hz,
  input  logic [6:0]         now_sec,
  input  logic [6:0]         now_min,
  input  logic [6:0]         now_hour,
  input  logic [5:0]         now_wday,
  input  logic [5:0]         now_mday,
  input  logic [7:0]         al1_sec,
  input  logic [7:0]         al1_min,
  input  logic [7:0]         al1_hour,
  input  logic [7:0]         al1_day,
  input  logic [7:0]         al2_min,
  input  logic [7:0]         al2_hour,
  input  logic [7:0]         al2_day,
  input  logic               ctrl_we,
  input  logic               stat_we,
  input  logic [7:0]         wr_data,
  input  logic               osc_stop,
  input  logic               on_backup,
  input  logic [N_RATES-1:0] wave_taps,
  output logic [7:0]         ctrl_q,
  output logic [7:0]         stat_q,
  output logic               irq_oe,
  output logic               irq_d
);
  localparam int RS_W = $clog2(N_RATES);
  localparam int NCH  = 2;

  logic [BYTE_W-1:0] ctrl_r;
  logic              osf_r;
  logic [NCH-1:0]    flag_r;
  logic [NCH-1:0]    hit;
  logic [BYTE_W-1:0] a_sec  [NCH];
  logic [BYTE_W-1:0] a_min  [NCH];
  logic [BYTE_W-1:0] a_hour [NCH];
  logic [BYTE_W-1:0] a_day  [NCH];

  assign a_sec[0]  = al1_sec;
  assign a_min[0]  = al1_min;
  assign a_hour[0] = al1_hour;
  assign a_day[0]  = al1_day;
  assign a_sec[1]  = ALL_MASKED;   // channel 2 has no seconds byte
  assign a_min[1]  = al2_min;
  assign a_hour[1] = al2_hour;
  assign a_day[1]  = al2_day;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      tod_alarm_match #(.NEED_SEC_ZERO(ch == 1)) u_match (
        .now_sec (now_sec),
        .now_min (now_min),
        .now_hour(now_hour),
        .now_wday(now_wday),
        .now_mday(now_mday),
        .al_sec  (a_sec[ch]),
        .al_min  (a_min[ch]),
        .al_hour (a_hour[ch]),
        .al_day  (a_day[ch]),
        .hit     (hit[ch])
      );

      // sticky flag: set by a match on the tick, cleared only by a 0 write
      always_ff @(posedge clk) begin
        if (rst)                                         flag_r[ch] <= 1'b0;
        else if (tick_1hz && hit[ch])                    flag_r[ch] <= 1'b1;
        else if (stat_we && !wr_data[SB_FLAG_LO + ch])   flag_r[ch] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          ctrl_r <= CTRL_RST;
    else if (ctrl_we) ctrl_r <= wr_data & CTRL_WMASK;
  end

  // oscillator-stop flag: edge set, write-zero clear, set on reset
  always_ff @(posedge clk) begin
    if (rst)
      osf_r <= 1'b1;
    else if (osc_stop || (ctrl_we && wr_data[CB_OSC_OFF] && !ctrl_r[CB_OSC_OFF]))
      osf_r <= 1'b1;
    else if (stat_we && !wr_data[SB_OSF])
      osf_r <= 1'b0;
  end

  tod_irq_out #(.N_RATES(N_RATES), .RS_W(RS_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .int_mode (ctrl_r[CB_INT_MOD]),
    .batt_en  (ctrl_r[CB_BATT_EN]),
    .on_backup(on_backup),
    .rate_sel (ctrl_r[CB_RATE_LO +: RS_W]),
    .wave_taps(wave_taps),
    .irq_req  (|(flag_r & ctrl_r[CB_IE_LO +: NCH])),
    .irq_oe   (irq_oe)
  );

  assign ctrl_q = ctrl_r;
  assign stat_q = {osf_r, {(BYTE_W-1-NCH){1'b0}}, flag_r};
  assign irq_d  = 1'b0;
endmodule

// File: rtl/tod_alarm_checker.sv
module tod_alarm_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic       ctrl_we,
  input logic       stat_we,
  input logic [7:0] wr_data,
  input logic       on_backup,
  input logic [3:0] wave_taps,
  input logic [7:0] ctrl_q,
  input logic [7:0] stat_q,
  input logic       irq_oe
);
  AST_FLAG1_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[0]) |-> $past(tick_1hz)); // R5
  AST_FLAG2_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[1]) |-> $past(tick_1hz)); // R4
  AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q[0]) |-> $past(stat_we && !wr_data[0])); // R6
  AST_OSF_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q[7]) |-> $past(stat_we && !wr_data[7])); // R10
  AST_BACKUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (on_backup && !ctrl_q[5]) |=> !irq_oe); // R9
  AST_INT_MODE: assert property (@(posedge clk) disable iff (rst)
    (!on_backup && ctrl_q[2]) |=> (irq_oe == $past(|(stat_q[1:0] & ctrl_q[1:0])))); // R7
  AST_WAVE_MODE: assert property (@(posedge clk) disable iff (rst)
    (!on_backup && !ctrl_q[2]) |=> (irq_oe == !$past(wave_taps[ctrl_q[4:3]]))); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(ctrl_q)); // R12
endmodule

bind tod_alarm_unit tod_alarm_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_1hz (tick_1hz),
  .ctrl_we  (ctrl_we),
  .stat_we  (stat_we),
  .wr_data  (wr_data),
  .on_backup(on_backup),
  .wave_taps(wave_taps),
  .ctrl_q   (ctrl_q),
  .stat_q   (stat_q),
  .irq_oe   (irq_oe)
);

// File: tb/tb_tod_alarm_unit.sv
`timescale 1ns/1ps
module tb_tod_alarm_unit;
  logic clk = 1'b0, rst = 1'b1, tick_1hz = 1'b0;
  logic [6:0] now_sec = 7'h10, now_min = 7'h00, now_hour = 7'h00;
  logic [5:0] now_wday = 6'd1, now_mday = 6'h01;
  logic [7:0] al1_sec = 8'h59, al1_min = 8'h80, al1_hour = 8'h80, al1_day = 8'h80;
  logic [7:0] al2_min = 8'h80, al2_hour = 8'h80, al2_day = 8'h80;
  logic ctrl_we = 1'b0, stat_we = 1'b0, osc_stop = 1'b0, on_backup = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] tcnt = 8'h00;
  logic [3:0] wave_taps;
  logic [7:0] ctrl_q, stat_q;
  logic irq_oe, irq_d;

  int checks = 0, errors = 0;
  bit started = 0;

  // behavioural reference state
  logic [7:0] m_ctrl = 8'h18;
  bit m_osf = 1, m_f1 = 0, m_f2 = 0, m_oe = 0;

  always #4 clk = ~clk;

  assign wave_taps = {tcnt[0], tcnt[2], tcnt[3], tcnt[6]};

  tod_alarm_unit dut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_wday(now_wday), .now_mday(now_mday),
    .al1_sec(al1_sec), .al1_min(al1_min), .al1_hour(al1_hour), .al1_day(al1_day),
    .al2_min(al2_min), .al2_hour(al2_hour), .al2_day(al2_day),
    .ctrl_we(ctrl_we), .stat_we(stat_we), .wr_data(wr_data),
    .osc_stop(osc_stop), .on_backup(on_backup), .wave_taps(wave_taps),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .irq_oe(irq_oe), .irq_d(irq_d)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int bcd(input int n);
    return ((n / 10) << 4) | (n % 10);
  endfunction

  function automatic bit ref_hit1();
    int need;
    bit ok = 1;
    case ({al1_day[7], al1_hour[7], al1_min[7], al1_sec[7]})
      4'b1111: need = 0;
      4'b1110: need = 1;
      4'b1100: need = 2;
      4'b1000: need = 3;
      default: need = 4;
    endcase
    if (need >= 1 && al1_sec[6:0] != now_sec)  ok = 0;
    if (need >= 2 && al1_min[6:0] != now_min)  ok = 0;
    if (need >= 3 && al1_hour[6:0] != now_hour) ok = 0;
    if (need >= 4 && al1_day[5:0] != (al1_day[6] ? now_wday : now_mday)) ok = 0;
    return ok;
  endfunction

  function automatic bit ref_hit2();
    int need;
    bit ok = (now_sec == 7'h00);
    case ({al2_day[7], al2_hour[7], al2_min[7]})
      3'b111:  need = 0;
      3'b110:  need = 1;
      3'b100:  need = 2;
      default: need = 3;
    endcase
    if (need >= 1 && al2_min[6:0] != now_min)  ok = 0;
    if (need >= 2 && al2_hour[6:0] != now_hour) ok = 0;
    if (need >= 3 && al2_day[5:0] != (al2_day[6] ? now_wday : now_mday)) ok = 0;
    return ok;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 8'h18; m_osf = 1; m_f1 = 0; m_f2 = 0; m_oe = 0;
    end else begin
      bit h1, h2;
      if (on_backup && !m_ctrl[5]) m_oe = 0;
      else if (m_ctrl[2])          m_oe = (m_f1 && m_ctrl[0]) || (m_f2 && m_ctrl[1]);
      else                         m_oe = !wave_taps[m_ctrl[4:3]];
      h1 = ref_hit1();
      h2 = ref_hit2();
      if (stat_we) begin
        if (!wr_data[0]) m_f1 = 0;
        if (!wr_data[1]) m_f2 = 0;
        if (!wr_data[7]) m_osf = 0;
      end
      if (tick_1hz && h1) m_f1 = 1;
      if (tick_1hz && h2) m_f2 = 1;
      if (osc_stop || (ctrl_we && wr_data[7] && !m_ctrl[7])) m_osf = 1;
      if (ctrl_we) m_ctrl = wr_data & 8'hBF;
    end
  end

  // compare every output on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      string oe_tag;
      oe_tag = (on_backup && !m_ctrl[5]) ? "R9 model" : (m_ctrl[2] ? "R7 model" : "R8 model");
      chk("R12 model ctrl", ctrl_q, m_ctrl);
      chk("R6 model status", stat_q, {m_osf, 5'b0, m_f2, m_f1});
      chk(oe_tag, {7'b0, irq_oe}, {7'b0, m_oe});
      chk("R11 irq_d", {7'b0, irq_d}, 8'h00);
    end
  end

  initial begin
    forever @(negedge clk) tcnt <= tcnt + 8'd1;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wctrl(input logic [7:0] v);
    ctrl_we = 1; wr_data = v; @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wstat(input logic [7:0] v);
    stat_we = 1; wr_data = v; @(negedge clk); stat_we = 0;
  endtask
  task automatic tick();
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 0; started = 1;
    chk("R1 ctrl reset", ctrl_q, 8'h18);
    chk("R1 status reset", stat_q, 8'h80);
    chk("R1 irq_oe reset", {7'b0, irq_oe}, 8'h00);
    cyc(20);                                 // square wave at reset rate
    wctrl(8'h05); chk("R12 ctrl write", ctrl_q, 8'h05);
    wctrl(8'h45); chk("R12 bit6 forced 0", ctrl_q, 8'h05);
    // R2 seconds compare, R5 tick gating
    now_sec = 7'h24; tick(); chk("R2 no match", stat_q, 8'h80);
    now_sec = 7'h59; cyc(3); chk("R5 no tick no flag", stat_q, 8'h80);
    tick(); chk("R2 seconds match", stat_q, 8'h81);
    chk("R11 irq lags flag", {7'b0, irq_oe}, 8'h00);
    cyc(1); chk("R7 irq asserted", {7'b0, irq_oe}, 8'h01);
    wstat(8'h01); chk("R6 write1 keeps flag, R10 osf clear", stat_q, 8'h01);
    wstat(8'h00); chk("R6 write0 clears", stat_q, 8'h00);
    cyc(1); chk("R7 irq released", {7'b0, irq_oe}, 8'h00);
    // R6 match beats same-cycle clear
    tick_1hz = 1; stat_we = 1; wr_data = 8'h00; @(negedge clk);
    tick_1hz = 0; stat_we = 0;
    chk("R6 set wins over clear", stat_q, 8'h01);
    wctrl(8'h04); cyc(1); chk("R7 enable off", {7'b0, irq_oe}, 8'h00);
    wstat(8'h00);
    // R4 channel 2
    wctrl(8'h06); al1_sec = 8'h58;
    tick(); chk("R4 sec not zero", stat_q, 8'h00);
    now_sec = 7'h00; tick(); chk("R4 minute fire", stat_q, 8'h02);
    cyc(1); chk("R7 alarm2 irq", {7'b0, irq_oe}, 8'h01);
    wstat(8'h00);
    al2_min = 8'h30; now_min = 7'h31; tick(); chk("R4 min mismatch", stat_q, 8'h00);
    now_min = 7'h30; now_sec = 7'h10; tick(); chk("R4 min ok sec not 00", stat_q, 8'h00);
    now_sec = 7'h00; tick(); chk("R4 min match", stat_q, 8'h02);
    wstat(8'h00);
    // R3 day/date select
    al1_sec = 8'h00; al1_min = 8'h00; al1_hour = 8'h12; al1_day = 8'h43;
    now_min = 7'h00; now_hour = 7'h12; now_wday = 6'd3; now_mday = 6'h15;
    tick(); chk("R3 weekday match", stat_q, 8'h01);
    wstat(8'h00);
    al1_day = 8'h03; tick(); chk("R3 date mismatch", stat_q, 8'h00);
    now_mday = 6'h03; tick(); chk("R3 date match", stat_q, 8'h01);
    // R9 backup release
    wctrl(8'h05); cyc(1); chk("R7 before backup", {7'b0, irq_oe}, 8'h01);
    on_backup = 1; cyc(1); chk("R9 released on backup", {7'b0, irq_oe}, 8'h00);
    wctrl(8'h25); cyc(1); chk("R9 battery enable", {7'b0, irq_oe}, 8'h01);
    on_backup = 0;
    // R10 oscillator-stop flag
    wstat(8'h00); chk("R10 all clear", stat_q, 8'h00);
    osc_stop = 1; @(negedge clk); osc_stop = 0;
    chk("R10 osc_stop sets", stat_q, 8'h80);
    wstat(8'h03); chk("R10 write0 clears", stat_q, 8'h00);
    wctrl(8'h85); chk("R10 off bit rise sets", stat_q, 8'h80);
    wstat(8'h7F); chk("R10 clear again", stat_q, 8'h00);
    wctrl(8'h85); chk("R10 no rise no set", stat_q, 8'h00);
    // R8 rate sweep under model compare
    for (int rs = 0; rs < 4; rs++) begin
      wctrl(8'(rs << 3));
      cyc(150);
    end
    // R2 mask pattern sweep under model compare
    wctrl(8'h07);
    for (int p = 0; p < 4; p++) begin
      al1_sec = 8'h30; al1_min = 8'h02; al1_hour = 8'h05; al1_day = 8'h80;
      if (p >= 0) al1_day[7] = 1;
      al1_hour[7] = (p < 3); al1_min[7] = (p < 2); al1_sec[7] = (p < 1);
      for (int k = 0; k < 60; k++) begin
        now_sec = 7'(bcd(k)); now_min = 7'(bcd(k % 3)); now_hour = 7'h05;
        tick();
        if (k % 4 == 3) wstat(8'h00);
      end
    end
    cyc(2);
    finish_run();
  end
endmodule